// File: doc/BRIEF.md
# Pipeline Exception Control Unit

This unit sits beside the hazard logic of a five-stage in-order pipeline and turns exception events into precise control-flow changes. It watches the decode (ID) and execute (EX) stages. A signed-arithmetic overflow is raised in EX. An unknown opcode is raised in ID. An external interrupt request arrives from outside the core. In the cycle an event is accepted, the unit kills the younger work: it clears the IF/ID register and forces the control bits of the affected stages to zero. When the event is an overflow, this also stops the faulting instruction from writing its result.

In the same cycle the unit steers the fetch address to a fixed handler entry. The PC register loads that address at the next edge, so the handler's first instruction is fetched in the cycle after detection. The unit also stores the PC of the instruction that must be restarted or examined, along with a code that says what happened. The handler reads both later.

Simultaneous events are resolved oldest-first. An interrupt is attached to the instruction in ID, so the instruction already in EX is allowed to finish.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, the saved PC output is 0, the cause code output is 0 (no event), and the flush, zero-control and redirect outputs are all low.
- R2: In a cycle with no accepted event, the flush, zero-control and redirect outputs are low, and the saved PC and cause keep their values at the next edge.
- R3: An overflow flag with EX valid raises, in the same cycle, the EX control-zero output (which cancels the faulting write), the ID control-zero output and the IF/ID flush.
- R4: Any accepted event raises redirect in the same cycle, with the redirect address equal to 0x80000180, so the handler entry is fetched in the next cycle.
- R5: After an accepted overflow, at the next edge the saved PC becomes the EX PC and the cause becomes 12.
- R6: An undefined-opcode flag with ID valid, and no accepted overflow, raises the IF/ID flush and the ID control-zero output but leaves the EX control-zero output low. At the next edge the saved PC becomes the ID PC and the cause becomes 10.
- R7: An interrupt request with ID valid, and no other accepted event, behaves like R6 except that the cause becomes 1. The EX instruction is not cancelled.
- R8: When events coincide, the priority is overflow, then undefined opcode, then interrupt. Only the winner's PC and cause are recorded.
- R9: An overflow flag with EX invalid, or an undefined-opcode flag with ID invalid, is ignored. An interrupt request is not accepted while ID is invalid and is accepted in the first cycle in which ID is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid_i | input | 1 | ID stage holds a real instruction |
| id_pc_i | input | XLEN | PC of the ID instruction |
| id_undef_i | input | 1 | Decoder found an unknown opcode in ID |
| ex_valid_i | input | 1 | EX stage holds a real instruction |
| ex_pc_i | input | XLEN | PC of the EX instruction |
| ex_ovf_i | input | 1 | ALU signed overflow in EX |
| irq_i | input | 1 | External interrupt request |
| flush_ifid_o | output | 1 | Clear the IF/ID register |
| zero_id_ctrl_o | output | 1 | Force ID-stage control bits to zero |
| zero_ex_ctrl_o | output | 1 | Force EX-stage control bits to zero, cancelling its write |
| redirect_o | output | 1 | Load the fetch PC with redirect_pc_o |
| redirect_pc_o | output | XLEN | Handler entry address |
| epc_o | output | XLEN | Saved PC of the excepting instruction |
| cause_o | output | 5 | Saved event code (0 none, 1 interrupt, 10 undefined, 12 overflow) |

## Verification
The assertions check the following on every cycle:
- An overflow in a valid EX stage always kills both stages and flushes IF/ID, and records the EX PC with code 12.
- An interrupt never cancels the EX instruction.
- The saved PC and cause hold steady whenever nothing is redirected.

The handler address itself, and the full priority ordering across all three sources, can only be shown by the bench's directed scenarios. The same applies to the rejection of flags from invalid stages and to a deferred interrupt being taken once ID becomes valid.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [4:0] {
        CAUSE_NONE  = 5'd0,
        CAUSE_IRQ   = 5'd1,
        CAUSE_UNDEF = 5'd10,
        CAUSE_OVF   = 5'd12
    } cause_e;

    // Outcome of event arbitration for one cycle
    typedef struct packed {
        logic   take;     // an event is accepted this cycle
        logic   from_ex;  // the accepted event belongs to the EX instruction
        cause_e code;     // code to record
    } evt_sel_t;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic     id_valid_i,
    input  logic     id_undef_i,
    input  logic     ex_valid_i,
    input  logic     ex_ovf_i,
    input  logic     irq_i,
    output evt_sel_t sel_o
);

    logic ovf_hit;
    logic undef_hit;
    logic irq_hit;

    assign ovf_hit   = ex_valid_i && ex_ovf_i;
    assign undef_hit = id_valid_i && id_undef_i;
    assign irq_hit   = id_valid_i && irq_i;

    // Oldest instruction wins; an interrupt is lowest
    always_comb begin
        sel_o = '{take: 1'b0, from_ex: 1'b0, code: CAUSE_NONE};
        if (ovf_hit) begin
            sel_o = '{take: 1'b1, from_ex: 1'b1, code: CAUSE_OVF};
        end else if (undef_hit) begin
            sel_o = '{take: 1'b1, from_ex: 1'b0, code: CAUSE_UNDEF};
        end else if (irq_hit) begin
            sel_o = '{take: 1'b1, from_ex: 1'b0, code: CAUSE_IRQ};
        end
    end

endmodule

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl
    import exc_pkg::*;
#(
    parameter int               XLEN   = 32,
    parameter logic [XLEN-1:0]  VECTOR = 32'h8000_0180
) (
    input  evt_sel_t        sel_i,
    output logic            flush_ifid_o,
    output logic            zero_id_o,
    output logic            zero_ex_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o
);

    always_comb begin
        flush_ifid_o  = sel_i.take;
        zero_id_o     = sel_i.take;
        zero_ex_o     = sel_i.take && sel_i.from_ex;
        redirect_o    = sel_i.take;
        redirect_pc_o = VECTOR;
    end

endmodule

// File: rtl/exc_record.sv
module exc_record
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  evt_sel_t        sel_i,
    input  logic [XLEN-1:0] id_pc_i,
    input  logic [XLEN-1:0] ex_pc_i,
    output logic [XLEN-1:0] epc_o,
    output cause_e          cause_o
);

    typedef struct packed {
        logic [XLEN-1:0] epc;
        cause_e          cause;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (sel_i.take) begin
            rec_d.epc   = sel_i.from_ex ? ex_pc_i : id_pc_i;
            rec_d.cause = sel_i.code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '{epc: '0, cause: CAUSE_NONE};
        end else begin
            rec_q <= rec_d;
        end
    end

    assign epc_o   = rec_q.epc;
    assign cause_o = rec_q.cause;

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int              XLEN   = 32,
    parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid_i,
    input  logic [XLEN-1:0] id_pc_i,
    input  logic            id_undef_i,
    input  logic            ex_valid_i,
    input  logic [XLEN-1:0] ex_pc_i,
    input  logic            ex_ovf_i,
    input  logic            irq_i,
    output logic            flush_ifid_o,
    output logic            zero_id_ctrl_o,
    output logic            zero_ex_ctrl_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic [XLEN-1:0] epc_o,
    output logic [4:0]      cause_o
);

    evt_sel_t sel;
    cause_e   cause;

    exc_arbiter u_arb (
        .id_valid_i (id_valid_i),
        .id_undef_i (id_undef_i),
        .ex_valid_i (ex_valid_i),
        .ex_ovf_i   (ex_ovf_i),
        .irq_i      (irq_i),
        .sel_o      (sel)
    );

    exc_flush_ctrl #(.XLEN(XLEN), .VECTOR(VECTOR)) u_flush (
        .sel_i         (sel),
        .flush_ifid_o  (flush_ifid_o),
        .zero_id_o     (zero_id_ctrl_o),
        .zero_ex_o     (zero_ex_ctrl_o),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o)
    );

    exc_record #(.XLEN(XLEN)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (sel),
        .id_pc_i (id_pc_i),
        .ex_pc_i (ex_pc_i),
        .epc_o   (epc_o),
        .cause_o (cause)
    );

    assign cause_o = cause;

    // R3: a valid overflow kills EX and ID and flushes IF/ID in the same cycle
    assert_ovf_kill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && ex_ovf_i) |-> (zero_ex_ctrl_o && zero_id_ctrl_o && flush_ifid_o));

    // R5: a valid overflow records the EX PC and code 12
    assert_ovf_record_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid_i && ex_ovf_i) |=> (epc_o == $past(ex_pc_i) && cause_o == 5'd12));

    // R2: the saved state holds when nothing is redirected
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |=> ($stable(epc_o) && $stable(cause_o)));

    // R7: an interrupt never cancels the EX instruction
    assert_irq_keeps_ex_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && id_valid_i && !(ex_valid_i && ex_ovf_i) && !id_undef_i)
            |-> (!zero_ex_ctrl_o && redirect_o));

    // R4: every kill is accompanied by a redirect
    assert_kill_redirects_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_id_ctrl_o || zero_ex_ctrl_o) |-> redirect_o);

endmodule

// File: tb/sim_exc_ctrl_unit.sv
module sim_exc_ctrl_unit;

    localparam int XLEN = 32;
    localparam logic [XLEN-1:0] VEC = 32'h8000_0180;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            id_valid = 1'b0;
    logic [XLEN-1:0] id_pc = '0;
    logic            id_undef = 1'b0;
    logic            ex_valid = 1'b0;
    logic [XLEN-1:0] ex_pc = '0;
    logic            ex_ovf = 1'b0;
    logic            irq = 1'b0;
    logic            flush_ifid, zero_id, zero_ex, redirect;
    logic [XLEN-1:0] redirect_pc, epc;
    logic [4:0]      cause;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    exc_ctrl_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .id_valid_i(id_valid), .id_pc_i(id_pc), .id_undef_i(id_undef),
        .ex_valid_i(ex_valid), .ex_pc_i(ex_pc), .ex_ovf_i(ex_ovf),
        .irq_i(irq),
        .flush_ifid_o(flush_ifid), .zero_id_ctrl_o(zero_id),
        .zero_ex_ctrl_o(zero_ex), .redirect_o(redirect),
        .redirect_pc_o(redirect_pc), .epc_o(epc), .cause_o(cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive after a falling edge, sample 1 ns later (combinational outputs)
    task automatic drive(input logic iv, input logic [31:0] ipc, input logic und,
                         input logic ev, input logic [31:0] epc_in, input logic ov,
                         input logic rq);
        @(negedge clk);
        id_valid = iv; id_pc = ipc; id_undef = und;
        ex_valid = ev; ex_pc = epc_in; ex_ovf = ov; irq = rq;
        #1;
    endtask

    // Let the edge pass, then return to an idle input state
    task automatic settle();
        @(posedge clk); #1;
        id_valid = 0; id_undef = 0; ex_valid = 0; ex_ovf = 0; irq = 0;
    endtask

    task automatic t_reset();
        check("R1 epc", epc, 32'h0);
        check("R1 cause", {27'b0, cause}, 32'd0);
        check("R1 ctrl", {28'b0, flush_ifid, zero_id, zero_ex, redirect}, 32'h0);
    endtask

    task automatic t_overflow();
        drive(1, 32'h44, 0, 1, 32'h40, 1, 0);
        check("R3 kill", {29'b0, flush_ifid, zero_id, zero_ex}, 32'h7);
        check("R4 redirect", {31'b0, redirect}, 32'h1);
        check("R4 vector", redirect_pc, VEC);
        settle();
        check("R5 epc", epc, 32'h40);
        check("R5 cause", {27'b0, cause}, 32'd12);
    endtask

    task automatic t_idle();
        drive(1, 32'h100, 0, 1, 32'h0FC, 0, 0);
        check("R2 ctrl", {28'b0, flush_ifid, zero_id, zero_ex, redirect}, 32'h0);
        settle();
        check("R2 epc", epc, 32'h40);
        check("R2 cause", {27'b0, cause}, 32'd12);
    endtask

    task automatic t_undef();
        drive(1, 32'h204, 1, 1, 32'h200, 0, 0);
        check("R6 kill", {29'b0, flush_ifid, zero_id, zero_ex}, 32'h6);
        check("R6 vector", redirect_pc, VEC);
        settle();
        check("R6 epc", epc, 32'h204);
        check("R6 cause", {27'b0, cause}, 32'd10);
    endtask

    task automatic t_irq();
        drive(1, 32'h308, 0, 1, 32'h304, 0, 1);
        check("R7 kill", {29'b0, flush_ifid, zero_id, zero_ex}, 32'h6);
        check("R7 redirect", {31'b0, redirect}, 32'h1);
        settle();
        check("R7 epc", epc, 32'h308);
        check("R7 cause", {27'b0, cause}, 32'd1);
    endtask

    task automatic t_priority();
        drive(1, 32'h404, 1, 1, 32'h400, 1, 1);
        check("R8 all kill", {31'b0, zero_ex}, 32'h1);
        settle();
        check("R8 ovf epc", epc, 32'h400);
        check("R8 ovf cause", {27'b0, cause}, 32'd12);
        drive(1, 32'h504, 1, 1, 32'h500, 0, 1);
        check("R8 undef ex", {31'b0, zero_ex}, 32'h0);
        settle();
        check("R8 undef epc", epc, 32'h504);
        check("R8 undef cause", {27'b0, cause}, 32'd10);
    endtask

    task automatic t_invalid();
        drive(0, 32'h604, 1, 0, 32'h600, 1, 0);
        check("R9 ignore ctrl", {28'b0, flush_ifid, zero_id, zero_ex, redirect}, 32'h0);
        settle();
        check("R9 ignore epc", epc, 32'h504);
        check("R9 ignore cause", {27'b0, cause}, 32'd10);
        drive(0, 32'h704, 0, 1, 32'h700, 0, 1);
        check("R9 irq wait", {31'b0, redirect}, 32'h0);
        settle();
        check("R9 irq wait epc", epc, 32'h504);
        drive(1, 32'h708, 0, 1, 32'h704, 0, 1);
        check("R9 irq taken", {31'b0, redirect}, 32'h1);
        settle();
        check("R9 irq epc", epc, 32'h708);
        check("R9 irq cause", {27'b0, cause}, 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_overflow();
        t_idle();
        t_undef();
        t_irq();
        t_priority();
        t_invalid();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule